// File: doc/BRIEF.md
# Event Timer Interrupt Router

This block sits between the comparators of a three-channel high-precision event timer and the interrupt controllers of the system. Each timer raises a fire signal when its comparator matches. The router turns that into an interrupt on a legacy 16-line 8259-style vector and on a 24-line I/O-APIC-style vector. It also carries the periodic-interval-timer (PIT) and real-time-clock (RTC) interrupt inputs onto their usual lines.

Software sets up the routing through a small register port that stands in for the system bus. One global bit switches on legacy replacement. When it is set, timers 0 and 1 take over the fixed lines of the PIT and RTC, and those two inputs are blocked. Each timer has its own trigger mode and a route select field. It also has a read-only capability mask that limits the APIC lines the timer may reach. A level-mode timer latches a status bit, and that bit holds its line asserted until software writes a 1 to clear it. All interrupt outputs are registered, so each output follows its cause one clock later.

Register map (4-bit address, 32-bit data): 0x0 global control, where bit 0 is the legacy replacement enable. 0x1 level status, where bit t belongs to timer t and writing 1 clears it. 0x4+t is the config of timer t: bit 0 is the trigger mode (0 edge, 1 level) and bits 12:8 are the route select. 0x8+t is the read-only capability mask of timer t, with bit n standing for APIC line n.

Top module: `etr_router`

## Requirements
- R1: After reset all outputs are 0, and the global, status and config registers read 0.
- R2: With legacy replacement clear, a PIT input of 1 drives 8259 line 0 and APIC line 2, and an RTC input of 1 drives 8259 line 8 and APIC line 8, one cycle later.
- R3: With legacy replacement set, the PIT and RTC inputs reach no output. Timer 0 drives 8259 line 0 and APIC line 2. Timer 1 drives 8259 line 8 and APIC line 8. The route select fields of both timers are ignored.
- R4: Timer 2 always drives 8259 line 11, and drives the APIC line that its route select names.
- R5: The capability masks read 0xF00F00 for timers 0 and 1 and 0xF00800 for timer 2 (APIC lines 11 and 20 to 23). Writes to them are ignored.
- R6: A route select whose APIC line is not set in the timer's capability mask, including values of 24 and above, drives no APIC line.
- R7: An edge-mode timer gives a single one-cycle pulse on its lines for each rising edge of its fire input, one cycle after that edge, even while fire stays high.
- R8: A level-mode timer sets its status bit on a rising fire edge and keeps its lines high until a 1 is written to that bit. The lines drop one cycle after the clearing write. Writing 0 leaves the bit and the lines unchanged.
- R9: When several sources map to the same output line, that line is the OR of those sources.
- R10: With legacy replacement clear, timers 0 and 1 drive only the APIC line that their route select names, and no 8259 line.
- R11: The global and config registers read back the values last written into their defined fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_fire | input | 3 | Comparator match signal of each timer |
| pit_irq | input | 1 | Interval timer interrupt input |
| rtc_irq | input | 1 | Real-time clock interrupt input |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| pic_irq | output | 16 | 8259-style interrupt lines |
| apic_irq | output | 24 | I/O-APIC-style interrupt lines |

## Verification
The hardest case to reach is a level-mode timer whose clearing write falls in the same cycle as the output register sampling the old status. The bench brings the status bit up with a fire pulse. It then issues a zero write followed by a one write to the status register, and the scoreboard expects the line to stay high through the clearing cycle and to drop on the next one. A second hard case is two sources converging on one line: either two timers routed to the same line, or a timer on the line that the RTC uses. The bench fires them in the same cycle and also on their own.

// File: rtl/etr_pkg.sv
package etr_pkg;
   localparam int unsigned REG_ADDR_W = 4;
   localparam int unsigned REG_DATA_W = 32;

   localparam logic [REG_ADDR_W-1:0] ADDR_GLOBAL   = 4'h0;
   localparam logic [REG_ADDR_W-1:0] ADDR_STATUS   = 4'h1;
   localparam logic [REG_ADDR_W-1:0] ADDR_CFG_BASE = 4'h4;
   localparam logic [REG_ADDR_W-1:0] ADDR_CAP_BASE = 4'h8;

   localparam int unsigned CFG_MODE_BIT  = 0;
   localparam int unsigned CFG_ROUTE_LSB = 8;

   // fixed line positions used by the legacy replacement routing
   localparam int unsigned LINE_PIT_PIC  = 0;
   localparam int unsigned LINE_PIT_APIC = 2;
   localparam int unsigned LINE_RTC      = 8;
   localparam int unsigned LINE_T2_PIC   = 11;

   localparam int unsigned LEGACY_TMRS = 2;
   localparam int unsigned MAX_TMRS    = 4;
endpackage

// File: rtl/etr_regs.sv
module etr_regs
   import etr_pkg::*;
#(
   parameter int unsigned NUM_TMR = 3,
   parameter int unsigned APIC_W  = 24,
   parameter int unsigned ROUTE_W = 5,
   parameter logic [NUM_TMR*APIC_W-1:0] ROUTE_CAP = '0
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              we,
   input  logic [REG_ADDR_W-1:0]             addr,
   input  logic [REG_DATA_W-1:0]             wdata,
   input  logic [NUM_TMR-1:0]                lvl_set,
   output logic [REG_DATA_W-1:0]             rdata,
   output logic                              legacy_en,
   output logic [NUM_TMR-1:0]                level_mode,
   output logic [NUM_TMR-1:0][ROUTE_W-1:0]   route,
   output logic [NUM_TMR-1:0]                status
);
   logic wr_global;
   logic wr_status;

   assign wr_global = we && (addr == ADDR_GLOBAL);
   assign wr_status = we && (addr == ADDR_STATUS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) legacy_en <= 1'b0;
      else if (wr_global) legacy_en <= wdata[0];
   end

   for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
      logic wr_cfg;
      logic clr;
      assign wr_cfg = we && (addr == ADDR_CFG_BASE + REG_ADDR_W'(t));
      assign clr    = wr_status && wdata[t];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            level_mode[t] <= 1'b0;
            route[t]      <= '0;
         end else if (wr_cfg) begin
            level_mode[t] <= wdata[CFG_MODE_BIT];
            route[t]      <= wdata[CFG_ROUTE_LSB +: ROUTE_W];
         end
      end

      // a new level event wins over a clear in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) status[t] <= 1'b0;
         else if (lvl_set[t]) status[t] <= 1'b1;
         else if (clr) status[t] <= 1'b0;
      end

      assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (clr && !lvl_set[t]) |=> !status[t]);
      assert_status_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (status[t] && !clr) |=> status[t]);
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_GLOBAL) rdata[0] = legacy_en;
      if (addr == ADDR_STATUS) rdata[NUM_TMR-1:0] = status;
      for (int t = 0; t < NUM_TMR; t++) begin
         if (addr == ADDR_CFG_BASE + REG_ADDR_W'(t)) begin
            rdata[CFG_MODE_BIT] = level_mode[t];
            rdata[CFG_ROUTE_LSB +: ROUTE_W] = route[t];
         end
         if (addr == ADDR_CAP_BASE + REG_ADDR_W'(t))
            rdata[APIC_W-1:0] = ROUTE_CAP[t*APIC_W +: APIC_W];
      end
   end

   wire unused_wdata = ^wdata;
endmodule

// File: rtl/etr_src.sv
module etr_src #(
   parameter int unsigned NUM_TMR = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_TMR-1:0] fire,
   input  logic [NUM_TMR-1:0] level_mode,
   input  logic [NUM_TMR-1:0] status,
   output logic [NUM_TMR-1:0] lvl_set,
   output logic [NUM_TMR-1:0] active
);
   logic [NUM_TMR-1:0] fire_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fire_q <= '0;
      else fire_q <= fire;
   end

   for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
      logic rise;
      assign rise       = fire[t] & ~fire_q[t];
      assign lvl_set[t] = rise & level_mode[t];
      assign active[t]  = level_mode[t] ? (status[t] | rise) : rise;

      assert_level_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
         lvl_set[t] |=> status[t]);
   end
endmodule

// File: rtl/etr_route.sv
module etr_route
   import etr_pkg::*;
#(
   parameter int unsigned NUM_TMR = 3,
   parameter int unsigned PIC_W   = 16,
   parameter int unsigned APIC_W  = 24,
   parameter int unsigned ROUTE_W = 5,
   parameter logic [NUM_TMR*APIC_W-1:0] ROUTE_CAP = '0
) (
   input  logic                            legacy_en,
   input  logic [NUM_TMR-1:0]              active,
   input  logic [NUM_TMR-1:0][ROUTE_W-1:0] route,
   input  logic                            pit_irq,
   input  logic                            rtc_irq,
   output logic [PIC_W-1:0]                pic_next,
   output logic [APIC_W-1:0]               apic_next
);
   logic [NUM_TMR-1:0][APIC_W-1:0] hits;

   for (genvar t = 0; t < NUM_TMR; t++) begin : g_hit
      localparam logic [APIC_W-1:0] CAP_T = ROUTE_CAP[t*APIC_W +: APIC_W];
      logic [APIC_W-1:0] sel_line;
      // a select past the last line shifts the bit out entirely
      assign sel_line = APIC_W'(1) << route[t];
      if (t < LEGACY_TMRS) begin : g_replaceable
         assign hits[t] = (active[t] && !legacy_en) ? (sel_line & CAP_T) : '0;
      end else begin : g_programmable
         assign hits[t] = active[t] ? (sel_line & CAP_T) : '0;
      end
   end

   always_comb begin
      pic_next  = '0;
      apic_next = '0;
      if (legacy_en) begin
         pic_next[LINE_PIT_PIC]   = active[0];
         apic_next[LINE_PIT_APIC] = active[0];
         pic_next[LINE_RTC]       = active[1];
         apic_next[LINE_RTC]      = active[1];
      end else begin
         pic_next[LINE_PIT_PIC]   = pit_irq;
         apic_next[LINE_PIT_APIC] = pit_irq;
         pic_next[LINE_RTC]       = rtc_irq;
         apic_next[LINE_RTC]      = rtc_irq;
      end
      pic_next[LINE_T2_PIC] = pic_next[LINE_T2_PIC] | active[2];
      for (int t = 0; t < NUM_TMR; t++) apic_next = apic_next | hits[t];
   end
endmodule

// File: rtl/etr_router.sv
module etr_router
   import etr_pkg::*;
#(
   parameter int unsigned NUM_TMR = 3,
   parameter int unsigned PIC_W   = 16,
   parameter int unsigned APIC_W  = 24,
   parameter int unsigned ROUTE_W = 5,
   parameter logic [NUM_TMR*APIC_W-1:0] ROUTE_CAP = {24'hF00800, 24'hF00F00, 24'hF00F00}
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_TMR-1:0]    tmr_fire,
   input  logic                  pit_irq,
   input  logic                  rtc_irq,
   input  logic                  reg_we,
   input  logic [REG_ADDR_W-1:0] reg_addr,
   input  logic [REG_DATA_W-1:0] reg_wdata,
   output logic [REG_DATA_W-1:0] reg_rdata,
   output logic [PIC_W-1:0]      pic_irq,
   output logic [APIC_W-1:0]     apic_irq
);
   function automatic logic [APIC_W-1:0] reachable_lines();
      logic [APIC_W-1:0] m;
      m = '0;
      for (int t = 0; t < NUM_TMR; t++) m = m | ROUTE_CAP[t*APIC_W +: APIC_W];
      m[LINE_PIT_APIC] = 1'b1;
      m[LINE_RTC]      = 1'b1;
      return m;
   endfunction
   localparam logic [APIC_W-1:0] REACHABLE = reachable_lines();

   initial begin
      assert_cfg_tmrs: assert (NUM_TMR >= 3 && NUM_TMR <= MAX_TMRS)
         else $fatal(1, "timer count out of range");
      assert_cfg_pic: assert (PIC_W > LINE_T2_PIC && PIC_W <= REG_DATA_W)
         else $fatal(1, "8259 vector too narrow");
      assert_cfg_apic: assert (APIC_W >= 24 && APIC_W <= REG_DATA_W)
         else $fatal(1, "APIC vector width out of range");
      assert_cfg_route: assert ((1 << ROUTE_W) >= APIC_W && CFG_ROUTE_LSB + ROUTE_W <= REG_DATA_W)
         else $fatal(1, "route field cannot address every line");
   end

   logic                            legacy_en;
   logic [NUM_TMR-1:0]              level_mode;
   logic [NUM_TMR-1:0][ROUTE_W-1:0] route;
   logic [NUM_TMR-1:0]              status;
   logic [NUM_TMR-1:0]              lvl_set;
   logic [NUM_TMR-1:0]              active;
   logic [PIC_W-1:0]                pic_next;
   logic [APIC_W-1:0]               apic_next;

   etr_regs #(
      .NUM_TMR(NUM_TMR), .APIC_W(APIC_W), .ROUTE_W(ROUTE_W), .ROUTE_CAP(ROUTE_CAP)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .lvl_set(lvl_set), .rdata(reg_rdata), .legacy_en(legacy_en),
      .level_mode(level_mode), .route(route), .status(status)
   );

   etr_src #(.NUM_TMR(NUM_TMR)) u_src (
      .clk(clk), .rst_n(rst_n), .fire(tmr_fire), .level_mode(level_mode),
      .status(status), .lvl_set(lvl_set), .active(active)
   );

   etr_route #(
      .NUM_TMR(NUM_TMR), .PIC_W(PIC_W), .APIC_W(APIC_W), .ROUTE_W(ROUTE_W), .ROUTE_CAP(ROUTE_CAP)
   ) u_route (
      .legacy_en(legacy_en), .active(active), .route(route),
      .pit_irq(pit_irq), .rtc_irq(rtc_irq),
      .pic_next(pic_next), .apic_next(apic_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pic_irq  <= '0;
         apic_irq <= '0;
      end else begin
         pic_irq  <= pic_next;
         apic_irq <= apic_next;
      end
   end

   assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!legacy_en && pit_irq) |=> (pic_irq[LINE_PIT_PIC] && apic_irq[LINE_PIT_APIC]));
   assert_pit_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (legacy_en && !active[0]) |=> !pic_irq[LINE_PIT_PIC]);
   assert_legacy_t0_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (legacy_en && active[0]) |=> (pic_irq[LINE_PIT_PIC] && apic_irq[LINE_PIT_APIC]));
   assert_t2_pic_R4: assert property (@(posedge clk) disable iff (!rst_n)
      active[2] |=> pic_irq[LINE_T2_PIC]);
   assert_cap_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (apic_irq & ~REACHABLE) == '0);
   assert_level_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (level_mode[2] && status[2]) |=> pic_irq[LINE_T2_PIC]);
endmodule

// File: tb/etr_router_test.sv
`timescale 1ns/1ps
module etr_router_test;
   localparam int N = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] fire = '0;
   logic        pit = 1'b0;
   logic        rtc = 1'b0;
   logic        we = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [15:0] pic;
   logic [23:0] apic;

   always #2 clk = ~clk;

   etr_router uut (
      .clk(clk), .rst_n(rst_n), .tmr_fire(fire), .pit_irq(pit), .rtc_irq(rtc),
      .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
      .pic_irq(pic), .apic_irq(apic)
   );

   typedef struct {
      int          cyc;
      logic [15:0] pic;
      logic [23:0] apic;
      string       req;
   } exp_t;

   exp_t sb[$];
   int   cyc = 0;
   int   checks = 0;
   int   fails = 0;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare every expected item that falls due in this cycle
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (pic !== e.pic || apic !== e.apic) begin
            fails++;
            $display("FAIL %s: pic=%h apic=%h expected pic=%h apic=%h",
                     e.req, pic, apic, e.pic, e.apic);
         end
      end
   end

   function automatic logic [23:0] b(input int n);
      return 24'(1) << n;
   endfunction

   function automatic logic [31:0] cfgw(input bit lvl, input int rt);
      return {19'd0, 5'(rt), 7'd0, lvl};
   endfunction

   task automatic drive(input logic w, input logic [3:0] a, input logic [31:0] d,
                        input logic [N-1:0] f, input logic p, input logic r,
                        input bit chk, input logic [15:0] ep, input logic [23:0] ea,
                        input string req);
      @(negedge clk);
      we = w; addr = a; wdata = d; fire = f; pit = p; rtc = r;
      if (chk) sb.push_back('{cyc + 1, ep, ea, req});
   endtask

   task automatic stim(input logic [N-1:0] f, input logic p, input logic r,
                       input logic [15:0] ep, input logic [23:0] ea, input string req);
      drive(1'b0, 4'h0, 32'h0, f, p, r, 1'b1, ep, ea, req);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d,
                     input logic [15:0] ep, input logic [23:0] ea, input string req);
      drive(1'b1, a, d, '0, 1'b0, 1'b0, 1'b1, ep, ea, req);
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
      drive(1'b0, a, 32'h0, '0, 1'b0, 1'b0, 1'b0, '0, '0, req);
      #1;
      checks++;
      if (rdata !== exp) begin
         fails++;
         $display("FAIL %s: rdata=%h expected %h (addr %h)", req, rdata, exp, a);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      stim('0, 0, 0, 16'h0, 24'h0, "R1 outputs after reset");
      rd(4'h0, 32'h0, "R1 global");
      rd(4'h1, 32'h0, "R1 status");
      rd(4'h4, 32'h0, "R1 cfg0");
      rd(4'h6, 32'h0, "R1 cfg2");

      // R5 capability masks, read-only
      rd(4'h8, 32'h00F00F00, "R5 cap0");
      rd(4'h9, 32'h00F00F00, "R5 cap1");
      rd(4'hA, 32'h00F00800, "R5 cap2");
      wr(4'hA, 32'hFFFFFFFF, 16'h0, 24'h0, "R5 cap write no output");
      rd(4'hA, 32'h00F00800, "R5 cap write ignored");

      // R2 pass-through with legacy replacement clear
      stim('0, 1, 0, 16'h0001, b(2), "R2 pit");
      stim('0, 0, 1, 16'h0100, b(8), "R2 rtc");
      stim('0, 1, 1, 16'h0101, b(2) | b(8), "R2 pit and rtc");
      stim('0, 0, 0, 16'h0, 24'h0, "R2 idle");

      // R10 / R7 programmable routing of timer 0, edge pulses
      wr(4'h4, cfgw(0, 20), 16'h0, 24'h0, "R10 cfg write");
      rd(4'h4, cfgw(0, 20), "R11 cfg0 readback");
      stim(3'b001, 0, 0, 16'h0, b(20), "R10 t0 routed to apic 20");
      stim(3'b000, 0, 0, 16'h0, 24'h0, "R7 pulse ends");
      stim(3'b001, 0, 0, 16'h0, b(20), "R7 held fire first cycle");
      stim(3'b001, 0, 0, 16'h0, 24'h0, "R7 held fire single pulse");
      stim(3'b000, 0, 0, 16'h0, 24'h0, "R7 idle");

      // R6 out-of-mask selects
      wr(4'h5, cfgw(0, 5), 16'h0, 24'h0, "R6 cfg1 write");
      stim(3'b010, 0, 0, 16'h0, 24'h0, "R6 line 5 not capable");
      stim(3'b000, 0, 0, 16'h0, 24'h0, "R6 idle");
      wr(4'h5, cfgw(0, 30), 16'h0, 24'h0, "R6 cfg1 write");
      stim(3'b010, 0, 0, 16'h0, 24'h0, "R6 select beyond vector");
      stim(3'b000, 0, 0, 16'h0, 24'h0, "R6 idle");
      wr(4'h5, cfgw(0, 21), 16'h0, 24'h0, "R10 cfg1 write");
      stim(3'b010, 0, 0, 16'h0, b(21), "R10 t1 routed to apic 21");
      stim(3'b000, 0, 0, 16'h0, 24'h0, "R10 idle");

      // R9 shared lines
      wr(4'h4, cfgw(0, 11), 16'h0, 24'h0, "R9 cfg0 write");
      wr(4'h6, cfgw(0, 11), 16'h0, 24'h0, "R9 cfg2 write");
      stim(3'b101, 0, 0, 16'h0800, b(11), "R9 t0 and t2 on line 11");
      stim(3'b000, 0, 0, 16'h0, 24'h0, "R9 idle");
      stim(3'b001, 0, 0, 16'h0, b(11), "R9 t0 alone on line 11");
      stim(3'b000, 0, 0, 16'h0, 24'h0, "R9 idle");
      wr(4'h5, cfgw(0, 8), 16'h0, 24'h0, "R9 cfg1 write");
      stim(3'b010, 0, 1, 16'h0100, b(8), "R9 t1 and rtc on line 8");
      stim(3'b000, 0, 1, 16'h0100, b(8), "R9 rtc alone on line 8");
      stim(3'b000, 0, 0, 16'h0, 24'h0, "R9 idle");

      // R4 timer 2
      wr(4'h6, cfgw(0, 23), 16'h0, 24'h0, "R4 cfg2 write");
      stim(3'b100, 0, 0, 16'h0800, b(23), "R4 t2 to pic 11 and apic 23");
      stim(3'b000, 0, 0, 16'h0, 24'h0, "R4 idle");
      wr(4'h6, cfgw(0, 12), 16'h0, 24'h0, "R6 cfg2 write");
      stim(3'b100, 0, 0, 16'h0800, 24'h0, "R6 t2 line 12 not capable");
      stim(3'b000, 0, 0, 16'h0, 24'h0, "R6 idle");

      // R3 legacy replacement
      wr(4'h4, cfgw(0, 20), 16'h0, 24'h0, "R3 cfg0 write");
      wr(4'h5, cfgw(0, 21), 16'h0, 24'h0, "R3 cfg1 write");
      wr(4'h0, 32'h1, 16'h0, 24'h0, "R3 enable legacy");
      rd(4'h0, 32'h1, "R11 global readback");
      stim(3'b000, 1, 1, 16'h0, 24'h0, "R3 pit and rtc blocked");
      stim(3'b001, 0, 0, 16'h0001, b(2), "R3 t0 fixed lines");
      stim(3'b000, 0, 0, 16'h0, 24'h0, "R3 idle");
      stim(3'b010, 0, 0, 16'h0100, b(8), "R3 t1 fixed lines");
      stim(3'b000, 0, 0, 16'h0, 24'h0, "R3 idle");
      stim(3'b011, 1, 1, 16'h0101, b(2) | b(8), "R3 both timers, inputs blocked");
      stim(3'b000, 0, 0, 16'h0, 24'h0, "R3 idle");
      wr(4'h0, 32'h0, 16'h0, 24'h0, "R3 disable legacy");

      // R8 level mode on timer 2
      wr(4'h6, cfgw(1, 22), 16'h0, 24'h0, "R8 cfg2 write");
      stim(3'b100, 0, 0, 16'h0800, b(22), "R8 level asserts");
      stim(3'b000, 0, 0, 16'h0800, b(22), "R8 level held");
      rd(4'h1, 32'h4, "R8 status set");
      wr(4'h1, 32'h0, 16'h0800, b(22), "R8 zero write");
      stim(3'b000, 0, 0, 16'h0800, b(22), "R8 zero write no effect");
      rd(4'h1, 32'h4, "R8 status after zero write");
      wr(4'h1, 32'h4, 16'h0800, b(22), "R8 clearing cycle");
      stim(3'b000, 0, 0, 16'h0, 24'h0, "R8 cleared");
      rd(4'h1, 32'h0, "R8 status cleared");
      rd(4'h6, cfgw(1, 22), "R11 cfg2 readback");

      stim(3'b000, 0, 0, 16'h0, 24'h0, "R1 final idle");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule